// File: doc/BRIEF.md
# Leaf Page Entry Access Checker

This block sits at the end of a radix translation walk. When the walker has fetched a 64-bit page table entry, it presents the entry with a one-cycle valid strobe. Alongside the entry it gives three flags for the access being attempted: privileged, instruction fetch and store. The block then decides how the walk continues.

There are four outcomes. An entry without the leaf bit goes back to the walker for another directory level. A leaf entry that passes both the access-authority check and the reference/change check allows a translation-buffer load. Any other leaf entry ends the walk with exactly one error flag. The entry's two-bit storage attribute is forwarded with every verdict.

All results are registered. The verdict for an entry appears on the clock edge that samples its strobe, together with a one-cycle done pulse. It then stays unchanged until the next strobe, whatever happens on the inputs in between. Updating the reference and change bits in memory is left to the walker.

Top module: `pte_leaf_checker`

## Requirements
- R1: While reset is low at a clock edge, done, all four outcome flags and the attribute output are cleared to zero on that edge.
- R2: A strobe sampled at clock edge N raises done for exactly the cycle after edge N. Done is low in any cycle that follows an edge without a strobe. Back-to-back strobes give back-to-back done cycles.
- R3: When bit 62 (leaf) of the sampled entry is clear, only next_level is set. No permission or reference/change check is reported.
- R4: When bit 3 (privileged-only) of a leaf entry is set and the access is not privileged, the permission check fails whatever the grant bits are.
- R5: For a data access (fetch flag low), permission holds when bit 1 (load/store grant) is set, or when bit 2 (load-only grant) is set and the access is not a store.
- R6: For an instruction fetch, permission holds only when bit 0 (execute grant) is set and bit 5 (cache-inhibit, the upper attribute bit) is clear.
- R7: The reference/change check passes when bit 8 (referenced) is set and either bit 7 (changed) is set or the access is not a store.
- R8: For a leaf entry, exactly one of tlb_load, perm_err and rc_err is set. tlb_load is set when both checks pass. A permission failure reports perm_err alone, even when the reference/change check also fails.
- R9: attr carries bits 5:4 of the sampled entry: 00 normal memory, 01 strongly ordered, 10 non-idempotent, 11 tolerant I/O.
- R10: Outputs depend only on the inputs sampled with the strobe. Changes to the entry or the flags while the strobe is low leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Strobe: sample the entry and flags this cycle |
| pte_i | input | 64 | Fetched page table entry |
| priv_i | input | 1 | Access is privileged |
| iside_i | input | 1 | Access is an instruction fetch |
| store_i | input | 1 | Access is a store |
| done_o | output | 1 | One-cycle pulse marking a new verdict |
| tlb_load_o | output | 1 | Both checks passed |
| perm_err_o | output | 1 | Access-authority failure |
| rc_err_o | output | 1 | Reference/change failure (permission passed) |
| next_level_o | output | 1 | Entry is not a leaf |
| attr_o | output | 2 | Storage attribute of the sampled entry |

## Verification
Every verdict, and its done pulse, is due one clock edge after the strobe. The bench therefore records the edge count when it issues a stimulus and expects the matching result at the falling edge that follows the next rising edge. The scoreboard flags a verdict that arrives early or late, and a done pulse that has no outstanding stimulus. For the hold behaviour, the bench changes the inputs with the strobe low for several cycles and compares the held outputs against the last expected verdict at each falling edge.

// File: rtl/pte_chk_pkg.sv
// Package: bit positions of the leaf entry fields and the verdict type.
// Assumes LSB-0 numbering of the 64-bit entry.
package pte_chk_pkg;
    localparam int PTE_W    = 64;
    localparam int LEAF_POS = 62;
    localparam int REF_POS  = 8;
    localparam int CHG_POS  = 7;
    localparam int ATT_LO   = 4;
    localparam int ATT_W    = 2;
    localparam int CI_POS   = ATT_LO + ATT_W - 1;
    localparam int AUTH_LO  = 0;
    localparam int AUTH_W   = 4;

    typedef enum logic [ATT_W-1:0] {
        ATT_NORMAL   = 2'b00,
        ATT_ORDERED  = 2'b01,
        ATT_NONIDEM  = 2'b10,
        ATT_TOLERANT = 2'b11
    } attr_e;

    typedef struct packed {
        logic  next_level;
        logic  tlb_load;
        logic  perm_err;
        logic  rc_err;
        attr_e attr;
    } verdict_t;
endpackage

// File: rtl/pte_access_auth.sv
// Access-authority decode. Takes the 4-bit authority field
// {priv_only, load_only, load_store, exec} and the cache-inhibit bit and
// says whether the attempted access is allowed. Purely combinational.
module pte_access_auth #(
    parameter int AUTH_W = 4
) (
    input  logic [AUTH_W-1:0] auth_i,
    input  logic              ci_i,
    input  logic              priv_i,
    input  logic              iside_i,
    input  logic              store_i,
    output logic              perm_ok_o
);
    localparam int PRIV_B = AUTH_W - 1;
    localparam int LDO_B  = AUTH_W - 2;
    localparam int LDST_B = AUTH_W - 3;
    localparam int EXE_B  = AUTH_W - 4;

    // Privilege gate first, then the fetch or data-side grant.
    always_comb begin
        perm_ok_o = 1'b0;
        if (priv_i || !auth_i[PRIV_B]) begin
            if (iside_i)
                perm_ok_o = auth_i[EXE_B] && !ci_i;
            else
                perm_ok_o = auth_i[LDST_B] || (auth_i[LDO_B] && !store_i);
        end
    end
endmodule

// File: rtl/pte_rc_eval.sv
// Reference/change check: an access needs the referenced bit, and a store
// additionally needs the changed bit. Purely combinational.
module pte_rc_eval (
    input  logic ref_i,
    input  logic chg_i,
    input  logic store_i,
    output logic rc_ok_o
);
    // Referenced is always needed; changed only for stores.
    always_comb rc_ok_o = ref_i && (chg_i || !store_i);
endmodule

// File: rtl/pte_leaf_checker.sv
// Top: samples a fetched entry on valid_i, runs the authority and
// reference/change checks, and registers a single verdict plus a done pulse.
// Assumes valid_i is a one-cycle strobe per entry; outputs hold between strobes.
module pte_leaf_checker
    import pte_chk_pkg::*;
#(
    parameter int W = PTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] pte_i,
    input  logic         priv_i,
    input  logic         iside_i,
    input  logic         store_i,
    output logic         done_o,
    output logic         tlb_load_o,
    output logic         perm_err_o,
    output logic         rc_err_o,
    output logic         next_level_o,
    output logic [1:0]   attr_o
);
    localparam int PRIV_POS = AUTH_LO + AUTH_W - 1;

    logic     perm_ok, rc_ok;
    verdict_t verdict_d, verdict_q;
    logic     done_q;

    pte_access_auth #(.AUTH_W(AUTH_W)) u_auth (
        .auth_i   (pte_i[AUTH_LO +: AUTH_W]),
        .ci_i     (pte_i[CI_POS]),
        .priv_i   (priv_i),
        .iside_i  (iside_i),
        .store_i  (store_i),
        .perm_ok_o(perm_ok)
    );

    pte_rc_eval u_rc (
        .ref_i  (pte_i[REF_POS]),
        .chg_i  (pte_i[CHG_POS]),
        .store_i(store_i),
        .rc_ok_o(rc_ok)
    );

    // Combine the two checks into one outcome; permission failure wins.
    always_comb begin
        verdict_d      = '0;
        verdict_d.attr = attr_e'(pte_i[ATT_LO +: ATT_W]);
        if (!pte_i[LEAF_POS])
            verdict_d.next_level = 1'b1;
        else if (perm_ok && rc_ok)
            verdict_d.tlb_load = 1'b1;
        else begin
            verdict_d.perm_err = !perm_ok;
            verdict_d.rc_err   = perm_ok;
        end
    end

    // Capture the verdict on the strobe and pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= valid_i;
            if (valid_i)
                verdict_q <= verdict_d;
        end
    end

    assign done_o       = done_q;
    assign tlb_load_o   = verdict_q.tlb_load;
    assign perm_err_o   = verdict_q.perm_err;
    assign rc_err_o     = verdict_q.rc_err;
    assign next_level_o = verdict_q.next_level;
    assign attr_o       = verdict_q.attr;

    // R2
    done_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> done_o);

    // R2
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !done_o);

    // R8
    single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $countones({tlb_load_o, perm_err_o, rc_err_o, next_level_o}) == 1);

    // R3
    nonleaf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !pte_i[LEAF_POS]) |=> next_level_o);

    // R4
    priv_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pte_i[LEAF_POS] && !priv_i && pte_i[PRIV_POS]) |=> perm_err_o);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable({tlb_load_o, perm_err_o, rc_err_o, next_level_o, attr_o}));
endmodule

// File: tb/pte_leaf_checker_test.sv
module pte_leaf_checker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [63:0] pte_i = '0;
    logic        priv_i = 1'b0, iside_i = 1'b0, store_i = 1'b0;
    logic        done_o, tlb_load_o, perm_err_o, rc_err_o, next_level_o;
    logic [1:0]  attr_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [5:0] exp_q[$];
    int         due_q[$];
    string      tag_q[$];
    logic [5:0] last_exp = '0;

    always #2 clk = ~clk;

    pte_leaf_checker uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pte_i(pte_i),
        .priv_i(priv_i), .iside_i(iside_i), .store_i(store_i),
        .done_o(done_o), .tlb_load_o(tlb_load_o), .perm_err_o(perm_err_o),
        .rc_err_o(rc_err_o), .next_level_o(next_level_o), .attr_o(attr_o)
    );

    function automatic logic [5:0] model(logic [63:0] p, logic pv, logic is, logic st);
        logic perm, rc;
        perm = 1'b0;
        if (pv || !p[3])                                       // R4
            perm = is ? (p[0] && !p[5]) : (p[1] || (p[2] && !st)); // R5 R6
        rc = p[8] && (p[7] || !st);                            // R7
        if (!p[62]) return {4'b1000, p[5:4]};                  // R3
        if (perm && rc) return {4'b0100, p[5:4]};              // R8
        return {1'b0, 1'b0, !perm, perm, p[5:4]};              // R8 R9
    endfunction

    function automatic logic [63:0] mk(logic leaf, logic [3:0] auth, logic [1:0] att,
                                       logic r, logic c);
        logic [63:0] p;
        p = 64'h3C5A_96F0_0F69_A5C3 & ~64'h4000_0000_0000_01BF;
        p[62] = leaf; p[8] = r; p[7] = c; p[5:4] = att; p[3:0] = auth;
        return p;
    endfunction

    task automatic send(logic [63:0] p, logic pv, logic is, logic st, string tag);
        @(negedge clk);
        pte_i = p; priv_i = pv; iside_i = is; store_i = st; valid_i = 1'b1;
        exp_q.push_back(model(p, pv, is, st));
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
        last_exp = model(p, pv, is, st);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
            pte_i = ~pte_i; priv_i = ~priv_i; iside_i = ~iside_i; store_i = ~store_i;
        end
    endtask

    // Monitor: pop and compare each verdict when its done pulse is due.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_q.size() > 0 && due_q[0] < cyc) begin
                checks++; errors++;
                $display("FAIL R2 %s: done missing, actual done=0 expected 1", tag_q[0]);
                void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
            end
            if (done_o) begin
                checks++;
                if (exp_q.size() == 0 || due_q[0] != cyc) begin
                    errors++;
                    $display("FAIL R2: unexpected done, actual done=1 expected 0");
                end else begin
                    logic [5:0] got, exp;
                    string t;
                    got = {next_level_o, tlb_load_o, perm_err_o, rc_err_o, attr_o};
                    exp = exp_q.pop_front(); void'(due_q.pop_front()); t = tag_q.pop_front();
                    if (got !== exp) begin
                        errors++;
                        $display("FAIL %s: actual %b expected %b", t, got, exp);
                    end
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R1
        if ({done_o, tlb_load_o, perm_err_o, rc_err_o, next_level_o, attr_o} !== 7'b0) begin
            errors++;
            $display("FAIL R1: actual %b expected 0",
                     {done_o, tlb_load_o, perm_err_o, rc_err_o, next_level_o, attr_o});
        end
        rst_n = 1'b1;
        idle(2);

        send(mk(0, 4'hF, 2'b01, 1, 1), 1, 0, 0, "R3 nonleaf");
        send(mk(1, 4'b1010, 2'b00, 1, 1), 0, 0, 0, "R4 user blocked");
        send(mk(1, 4'b1010, 2'b00, 1, 1), 1, 0, 1, "R4 priv allowed");
        send(mk(1, 4'b0100, 2'b00, 1, 0), 0, 0, 0, "R5 load-only load");
        send(mk(1, 4'b0100, 2'b00, 1, 1), 0, 0, 1, "R5 load-only store");
        send(mk(1, 4'b0010, 2'b00, 1, 1), 0, 0, 1, "R5 load/store store");
        send(mk(1, 4'b0001, 2'b00, 1, 1), 0, 0, 0, "R5 exec-only data");
        idle(1);
        send(mk(1, 4'b0001, 2'b01, 1, 0), 0, 1, 0, "R6 fetch ok");
        send(mk(1, 4'b0001, 2'b10, 1, 0), 0, 1, 0, "R6 fetch inhibited");
        send(mk(1, 4'b0001, 2'b11, 1, 0), 1, 1, 0, "R6 fetch inhibited priv");
        send(mk(1, 4'b0110, 2'b00, 1, 0), 0, 1, 0, "R6 fetch no exec");
        send(mk(1, 4'b0010, 2'b00, 0, 1), 0, 0, 0, "R7 unreferenced");
        send(mk(1, 4'b0010, 2'b00, 1, 0), 0, 0, 1, "R7 store unchanged");
        send(mk(1, 4'b0010, 2'b00, 1, 0), 0, 0, 0, "R7 load unchanged");
        send(mk(1, 4'b0100, 2'b00, 0, 0), 0, 0, 1, "R8 perm beats rc");
        send(mk(1, 4'b1000, 2'b00, 0, 0), 0, 1, 0, "R8 priv beats rc");
        for (int a = 0; a < 4; a++)
            send(mk(1, 4'b0010, 2'(a), 1, 1), 0, 0, 0, "R9 attr");
        send(mk(1, 4'b0010, 2'b10, 1, 1), 0, 0, 0, "R10 held verdict");
        idle(1);

        // R10: inputs wander with strobe low; outputs must hold.
        for (int i = 0; i < 4; i++) begin
            idle(1);
            checks++;
            if ({next_level_o, tlb_load_o, perm_err_o, rc_err_o, attr_o} !== last_exp
                || done_o !== 1'b0) begin
                errors++;
                $display("FAIL R10: actual %b/%b expected %b/0",
                         {next_level_o, tlb_load_o, perm_err_o, rc_err_o, attr_o}, done_o, last_exp);
            end
        end

        // R1: reset mid-run clears everything.
        send(mk(1, 4'b0010, 2'b11, 1, 1), 0, 0, 0, "R1 pre-reset");
        idle(1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        checks++;
        if ({done_o, tlb_load_o, perm_err_o, rc_err_o, next_level_o, attr_o} !== 7'b0) begin
            errors++;
            $display("FAIL R1: actual %b expected 0",
                     {done_o, tlb_load_o, perm_err_o, rc_err_o, next_level_o, attr_o});
        end
        rst_n = 1'b1;
        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: actual %0d pending expected 0", exp_q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule